// File: doc/BRIEF.md
# Double-Data-Rate Frame Serializer

This block sends one framed message at a time over a single serial data line together with a forwarded clock. It puts a new bit on every edge of the forwarded clock, rising and falling. Each system clock cycle produces one such edge, so the forwarded clock runs at half the system clock rate. A frame starts with four clock-only edges that carry no data. The start delimiter follows, then the frame type, the user byte, the payload, a CRC byte, the tag and the end delimiter. Four more clock-only edges close the frame, and the line then returns to idle.

The host pulses a start input while presenting the frame type, user byte, tag and payload. The block captures these values in that cycle, raises a busy flag while the frame is on the wire and gives a one-cycle done pulse when the frame has finished. The frame type selects a short payload of 16 bits or a long payload of 128 bits. The CRC byte is computed on the fly as the covered bits leave the block.

Top module: `ddr_frame_ser`

## Requirements
- R1: After reset, and whenever busy_o is low, sclk_o and sdo_o are both low. busy_o and done_o are low after reset.
- R2: A start_i pulse while busy_o is low is accepted only for frame type 4'b0100 (short payload) or 4'b0101 (long payload). busy_o is high in the cycle after acceptance. A start_i with any other type value leaves busy_o and sclk_o low.
- R3: start_i is ignored while busy_o is high. The frame on the wire is unchanged, and no further frame follows it. Inputs are sampled only in the cycle of acceptance.
- R4: The frame begins with four edges of sclk_o during which sdo_o is 0. sclk_o toggles once per system clock cycle while the frame is being sent, and sdo_o carries exactly one bit per sclk_o edge.
- R5: After the preamble, the bits go out in this order: start delimiter 1001, the 4-bit frame type, the 8-bit user byte, the payload, the 8-bit CRC, the 4-bit tag, and end delimiter 0110. Every field is sent most significant bit first.
- R6: A short frame sends payload_i[15:0] and ignores payload_i[127:16]. A long frame sends all of payload_i[127:0].
- R7: The CRC byte is a CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0x00 and no final inversion. It is computed MSB-first over the user byte followed by the payload bits that are actually sent.
- R8: The end delimiter is followed by four edges of sclk_o during which sdo_o is 0. sclk_o is then low.
- R9: done_o is high for exactly one cycle, one system cycle after the last postamble edge. busy_o falls in that same cycle, so a start in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one forwarded-clock edge per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to send a frame with the presented fields |
| ftype_i | input | 4 | Frame type: 4'b0100 short, 4'b0101 long |
| user_i | input | 8 | User byte |
| tag_i | input | 4 | Frame tag |
| payload_i | input | 128 | Payload; only bits [15:0] are used in a short frame |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| sclk_o | output | 1 | Forwarded clock |
| sdo_o | output | 1 | Serial data, one bit per sclk_o edge |

## Verification
Two events can fall in the same cycle: the done pulse that ends one frame and the acceptance of the next start, because busy_o drops in the done cycle. The bench provokes this by holding start_i high through a whole frame. It then checks that done lasts one cycle, that busy_o is high again in the next sample, and that the first frame's bit stream was not disturbed. It also raises start_i in the middle of a frame with different fields, and checks that both the captured stream and the idle state after done are unaffected.

// File: rtl/ddrfs_pkg.sv
package ddrfs_pkg;
  localparam int unsigned DLM_W  = 4;
  localparam int unsigned TYPE_W = 4;
  localparam int unsigned USER_W = 8;
  localparam int unsigned CRC_W  = 8;
  localparam int unsigned TAG_W  = 4;
  localparam int unsigned HEAD_W = DLM_W + TYPE_W;
  localparam int unsigned TAIL_W = TAG_W + DLM_W;

  localparam logic [DLM_W-1:0]  SOF_PAT    = 4'b1001;
  localparam logic [DLM_W-1:0]  EOF_PAT    = 4'b0110;
  localparam logic [TYPE_W-1:0] TYPE_SHORT = 4'b0100;
  localparam logic [TYPE_W-1:0] TYPE_LONG  = 4'b0101;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seq_st_t;
  typedef enum logic [2:0] {SEG_PRE, SEG_HEAD, SEG_BODY, SEG_CRC, SEG_TAIL, SEG_POST} seg_t;
endpackage

// File: rtl/dfs_rst_sync.sv
module dfs_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/dfs_seq.sv
module dfs_seq
  import ddrfs_pkg::*;
#(
  parameter int unsigned PAY_SHORT = 16,
  parameter int unsigned PAY_LONG  = 128,
  parameter int unsigned N_PRE     = 4,
  parameter int unsigned N_POST    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [TYPE_W-1:0] ftype_i,
  output logic              accept_o,
  output logic              step_o,
  output seg_t              seg_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned MAX_EDGES = N_PRE + HEAD_W + USER_W + PAY_LONG + CRC_W + TAIL_W + N_POST;
  localparam int unsigned CW        = $clog2(MAX_EDGES + 1);

  seq_st_t       st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          long_q, long_n;
  logic          done_q, done_n;

  logic [CW-1:0] pay_len;
  logic [CW-1:0] lim_pre, lim_head, lim_body, lim_crc, lim_tail, lim_post;
  logic          type_ok;

  assign type_ok  = (ftype_i == TYPE_SHORT) || (ftype_i == TYPE_LONG);
  assign accept_o = (st_q == ST_IDLE) && start_i && type_ok;

  // segment boundaries counted in forwarded-clock edges since acceptance
  always_comb begin
    pay_len  = long_q ? CW'(PAY_LONG) : CW'(PAY_SHORT);
    lim_pre  = CW'(N_PRE);
    lim_head = CW'(N_PRE + HEAD_W);
    lim_body = CW'(N_PRE + HEAD_W + USER_W) + pay_len;
    lim_crc  = lim_body + CW'(CRC_W);
    lim_tail = lim_crc + CW'(TAIL_W);
    lim_post = lim_tail + CW'(N_POST);
  end

  always_comb begin
    if (cnt_q < lim_pre)       seg_o = SEG_PRE;
    else if (cnt_q < lim_head) seg_o = SEG_HEAD;
    else if (cnt_q < lim_body) seg_o = SEG_BODY;
    else if (cnt_q < lim_crc)  seg_o = SEG_CRC;
    else if (cnt_q < lim_tail) seg_o = SEG_TAIL;
    else                       seg_o = SEG_POST;
  end

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    long_n = long_q;
    done_n = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept_o) begin
          st_n   = ST_RUN;
          cnt_n  = '0;
          long_n = (ftype_i == TYPE_LONG);
        end
      end
      ST_RUN: begin
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == lim_post - 1'b1) st_n = ST_FIN;
      end
      ST_FIN: begin
        st_n   = ST_IDLE;
        done_n = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      long_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      long_q <= long_n;
      done_q <= done_n;
    end
  end

  assign step_o = (st_q == ST_RUN);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/dfs_shift.sv
module dfs_shift
  import ddrfs_pkg::*;
#(
  parameter int unsigned PAY_SHORT = 16,
  parameter int unsigned PAY_LONG  = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                long_i,
  input  logic [TYPE_W-1:0]   ftype_i,
  input  logic [USER_W-1:0]   user_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  logic [PAY_LONG-1:0] payload_i,
  input  logic                body_sh_i,
  input  logic                tail_sh_i,
  output logic                body_bit_o,
  output logic                tail_bit_o
);
  localparam int unsigned SR_W  = HEAD_W + USER_W + PAY_LONG;
  localparam int unsigned ALIGN = PAY_LONG - PAY_SHORT;

  logic [SR_W-1:0]     sr_q, sr_n;
  logic [TAIL_W-1:0]   tl_q, tl_n;
  logic [PAY_LONG-1:0] pay_al;

  // short payload is moved to the top so it leaves first
  assign pay_al = long_i ? payload_i : (payload_i << ALIGN);

  always_comb begin
    sr_n = sr_q;
    if (load_i)         sr_n = {SOF_PAT, ftype_i, user_i, pay_al};
    else if (body_sh_i) sr_n = {sr_q[SR_W-2:0], 1'b0};
  end

  always_comb begin
    tl_n = tl_q;
    if (load_i)         tl_n = {tag_i, EOF_PAT};
    else if (tail_sh_i) tl_n = {tl_q[TAIL_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      tl_q <= '0;
    end else begin
      sr_q <= sr_n;
      tl_q <= tl_n;
    end
  end

  assign body_bit_o = sr_q[SR_W-1];
  assign tail_bit_o = tl_q[TAIL_W-1];
endmodule

// File: rtl/dfs_crc8.sv
module dfs_crc8
  import ddrfs_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 8'h07
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic upd_i,
  input  logic bit_i,
  input  logic shf_i,
  output logic msb_o
);
  logic [CRC_W-1:0] crc_q, crc_n;
  logic             fb;

  assign fb = crc_q[CRC_W-1] ^ bit_i;

  always_comb begin
    crc_n = crc_q;
    if (clr_i)      crc_n = '0;
    else if (upd_i) crc_n = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    else if (shf_i) crc_n = {crc_q[CRC_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_n;
  end

  assign msb_o = crc_q[CRC_W-1];
endmodule

// File: rtl/ddr_frame_ser.sv
module ddr_frame_ser
  import ddrfs_pkg::*;
#(
  parameter int unsigned PAY_SHORT = 16,
  parameter int unsigned PAY_LONG  = 128,
  parameter int unsigned N_PRE     = 4,
  parameter int unsigned N_POST    = 4,
  parameter logic [7:0]  CRC_POLY  = 8'h07
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [3:0]          ftype_i,
  input  logic [7:0]          user_i,
  input  logic [3:0]          tag_i,
  input  logic [PAY_LONG-1:0] payload_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                sclk_o,
  output logic                sdo_o
);
  logic rst_q;
  logic accept, step;
  seg_t seg;
  logic body_bit, tail_bit, crc_msb;
  logic body_sh, tail_sh, crc_upd, crc_shf;
  logic sclk_q, sclk_n, sdo_q, sdo_n;

  dfs_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_q)
  );

  dfs_seq #(
    .PAY_SHORT (PAY_SHORT),
    .PAY_LONG  (PAY_LONG),
    .N_PRE     (N_PRE),
    .N_POST    (N_POST)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_q),
    .start_i  (start_i),
    .ftype_i  (ftype_i),
    .accept_o (accept),
    .step_o   (step),
    .seg_o    (seg),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  assign body_sh = step && ((seg == SEG_HEAD) || (seg == SEG_BODY));
  assign tail_sh = step && (seg == SEG_TAIL);
  assign crc_upd = step && (seg == SEG_BODY);
  assign crc_shf = step && (seg == SEG_CRC);

  dfs_shift #(
    .PAY_SHORT (PAY_SHORT),
    .PAY_LONG  (PAY_LONG)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_q),
    .load_i     (accept),
    .long_i     (ftype_i == TYPE_LONG),
    .ftype_i    (ftype_i),
    .user_i     (user_i),
    .tag_i      (tag_i),
    .payload_i  (payload_i),
    .body_sh_i  (body_sh),
    .tail_sh_i  (tail_sh),
    .body_bit_o (body_bit),
    .tail_bit_o (tail_bit)
  );

  dfs_crc8 #(
    .POLY (CRC_POLY)
  ) u_crc (
    .clk   (clk),
    .rst_n (rst_q),
    .clr_i (accept),
    .upd_i (crc_upd),
    .bit_i (body_bit),
    .shf_i (crc_shf),
    .msb_o (crc_msb)
  );

  // output stage: one forwarded-clock edge and one data bit per active cycle
  always_comb begin
    sclk_n = sclk_q;
    sdo_n  = 1'b0;
    if (step) begin
      sclk_n = ~sclk_q;
      case (seg)
        SEG_HEAD, SEG_BODY: sdo_n = body_bit;
        SEG_CRC:            sdo_n = crc_msb;
        SEG_TAIL:           sdo_n = tail_bit;
        default:            sdo_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sclk_q <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_n;
      sdo_q  <= sdo_n;
    end
  end

  assign sclk_o = sclk_q;
  assign sdo_o  = sdo_q;
endmodule

// File: rtl/dfs_chk.sv
module dfs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [3:0] ftype_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       sclk_o,
  input logic       sdo_o
);
  logic type_ok;
  assign type_ok = (ftype_i == 4'b0100) || (ftype_i == 4'b0101);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !sdo_o));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && type_ok) |=> busy_o);

  // R2
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !type_ok) |=> !busy_o);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R4
  sclk_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o != $past(sclk_o)) |-> busy_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind ddr_frame_ser dfs_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_q),
  .start_i (start_i),
  .ftype_i (ftype_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sclk_o  (sclk_o),
  .sdo_o   (sdo_o)
);

// File: tb/ddr_frame_ser_test.sv
`timescale 1ns/1ps
module ddr_frame_ser_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   ft = '0;
  logic [3:0]   tg = '0;
  logic [7:0]   us = '0;
  logic [127:0] pl = '0;
  logic         busy, done, sclk, sdo;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  bit ex [0:255];
  bit gt [0:255];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_frame_ser uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ftype_i(ft), .user_i(us),
    .tag_i(tg), .payload_i(pl), .busy_o(busy), .done_o(done),
    .sclk_o(sclk), .sdo_o(sdo)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_ref(input logic [7:0] u, input logic [127:0] p, input int plen);
    logic [7:0] c;
    logic       b;
    c = 8'h00;
    for (int i = 7 + plen; i >= 0; i--) begin
      b = (i >= plen) ? u[i - plen] : p[i];
      if (c[7] ^ b) c = {c[6:0], 1'b0} ^ 8'h07;
      else          c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  task automatic cmp_range(input int lo, input int hi, input string req, input string what);
    int bad_at;
    bad_at = -1;
    for (int i = hi; i >= lo; i--) if (gt[i] != ex[i]) bad_at = i;
    if (bad_at < 0) chk(1'b1, req, what, 0, 0);
    else chk(1'b0, req, $sformatf("%s bit %0d", what, bad_at), gt[bad_at], ex[bad_at]);
  endtask

  task automatic run_frame(input logic [3:0] f, input logic [7:0] u, input logic [3:0] t,
                           input logic [127:0] p, input bit inject, input bit keep);
    int plen, nf, ne, ng, busy_bad, waitc;
    logic [7:0] c;
    logic prev;
    bit seen;
    plen = (f == 4'b0101) ? 128 : 16;
    nf   = 32 + plen;
    c    = crc_ref(u, p, plen);
    ne   = 0;
    for (int i = 0; i < 4; i++) begin ex[ne] = 1'b0; ne++; end
    for (int i = 3; i >= 0; i--) begin ex[ne] = 4'b1001 >> i; ne++; end
    for (int i = 3; i >= 0; i--) begin ex[ne] = f[i]; ne++; end
    for (int i = 7; i >= 0; i--) begin ex[ne] = u[i]; ne++; end
    for (int i = plen - 1; i >= 0; i--) begin ex[ne] = p[i]; ne++; end
    for (int i = 7; i >= 0; i--) begin ex[ne] = c[i]; ne++; end
    for (int i = 3; i >= 0; i--) begin ex[ne] = t[i]; ne++; end
    for (int i = 3; i >= 0; i--) begin ex[ne] = 4'b0110 >> i; ne++; end
    for (int i = 0; i < 4; i++) begin ex[ne] = 1'b0; ne++; end
    for (int i = 0; i < 256; i++) gt[i] = 1'b0;

    @(negedge clk);
    ft = f; us = u; tg = t; pl = p; start = 1'b1;
    prev = sclk; ng = 0; busy_bad = 0;
    for (int k = 1; k <= nf + 10; k++) begin
      @(negedge clk);
      if (sclk != prev) begin
        if (ng < 256) gt[ng] = sdo;
        ng++;
      end
      prev = sclk;
      if (k <= nf + 9) begin
        if (!busy || done) busy_bad++;
      end else begin
        chk(done && !busy, "R9", "done pulse with busy low one cycle after last post edge",
            {done, busy}, 2'b10);
        chk(!sclk && !sdo, "R8", "line idle after postamble", {sclk, sdo}, 0);
      end
      if (k == 1 && !keep) start = 1'b0;
      if (inject && k == 10) begin
        start = 1'b1;
        ft = (f == 4'b0101) ? 4'b0100 : 4'b0101;
        us = ~u; tg = ~t; pl = ~p;
      end
      if (inject && k == 11) start = 1'b0;
    end
    chk(busy_bad == 0, "R2", "busy high for whole frame", busy_bad, 0);
    chk(ng == nf + 8, "R4", "one bit per sclk edge, edge count", ng, nf + 8);
    cmp_range(0, 3, "R4", "preamble data");
    cmp_range(4, 11, "R5", "start delimiter and type");
    cmp_range(12, 19 + plen, "R6", "user byte and payload");
    cmp_range(20 + plen, 27 + plen, "R7", "crc byte");
    cmp_range(28 + plen, 35 + plen, "R5", "tag and end delimiter");
    cmp_range(36 + plen, 39 + plen, "R8", "postamble data");

    @(negedge clk);
    if (keep) begin
      chk(busy && !done, "R9", "start held through done is accepted at once", {busy, done}, 2'b10);
      start = 1'b0;
      seen = 1'b0;
      waitc = 0;
      while (!seen && waitc < 400) begin
        @(negedge clk);
        if (done) seen = 1'b1;
        waitc++;
      end
      chk(seen, "R9", "second back-to-back frame completes", seen, 1);
      @(negedge clk);
    end else if (inject) begin
      chk(!busy && !sclk, "R3", "start during busy spawns no frame", {busy, sclk}, 0);
    end
  endtask

  initial begin
    wait (cyc >= 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !sclk && !sdo, "R1", "outputs in reset", {busy, done, sclk, sdo}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !sclk && !sdo, "R1", "outputs after reset", {busy, done, sclk, sdo}, 0);

    // R2: sweep every type code, only 0100 and 0101 may start a frame
    for (int t = 0; t < 16; t++) begin
      if (t != 4 && t != 5) begin
        @(negedge clk);
        ft = 4'(t); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy && !sclk, $sformatf("R2 type %0d", t), "rejected type stays idle", {busy, sclk}, 0);
        @(negedge clk);
        chk(!busy && !sclk, $sformatf("R2 type %0d", t), "still idle one cycle later", {busy, sclk}, 0);
      end
    end

    // R6/R7 corner patterns
    run_frame(4'b0100, 8'h00, 4'h0, 128'h0, 1'b0, 1'b0);
    run_frame(4'b0100, 8'hFF, 4'hF, {128{1'b1}}, 1'b0, 1'b0);
    run_frame(4'b0101, 8'h00, 4'h0, 128'h0, 1'b0, 1'b0);
    run_frame(4'b0101, 8'hFF, 4'hF, {128{1'b1}}, 1'b0, 1'b0);

    // R5/R6/R7 short sweep; upper payload bits carry noise that must not appear
    for (int i = 0; i < 24; i++) begin
      run_frame(4'b0100, 8'(i * 37 + 5), 4'(i),
                {4{32'(i) * 32'h9E3779B1 + 32'h1234_0000}}, 1'b0, 1'b0);
    end

    // long sweep
    for (int i = 0; i < 6; i++) begin
      run_frame(4'b0101, 8'(i * 91 + 3), 4'(15 - i),
                {32'(i) * 32'h85EB_CA6B, 32'h0F0F_0F0F ^ 32'(i), 32'hC2B2_AE35 + 32'(i), ~(32'(i) << 5)},
                1'b0, 1'b0);
    end

    // R3: start mid-frame with different fields
    run_frame(4'b0100, 8'hA5, 4'h6, 128'h1357, 1'b1, 1'b0);
    run_frame(4'b0101, 8'h3C, 4'h9, {4{32'hDEAD_BEEF}}, 1'b1, 1'b0);

    // R9: done and next acceptance in the same cycle
    run_frame(4'b0100, 8'h5A, 4'h3, 128'hBEEF, 1'b0, 1'b1);
    run_frame(4'b0101, 8'hC3, 4'hC, {4{32'h0123_4567}}, 1'b0, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule